// File: doc/BRIEF.md
# Four-Phase Accumulator Processor

A small sequential processor built around a single accumulator, a program counter and an instruction register. Code and data share one memory. A phase counter moves every instruction through the same four steps: fetch, decode, prepare and execute. The instruction decoder looks at the current phase and the opcode and drives one set of control strobes. These strobes are the address-mux select, the instruction-register load, the PC increment, the PC load, the accumulator load, the accumulator shift and the ALU operation select.

An instruction word is 16 bits. The opcode sits in bits 15:12 and the operand address in bits 11:0. A single memory port serves instruction fetch, operand read and store. The address mux picks the PC during fetch and the instruction's address field in every other phase. Memory reads are combinational and writes are clocked. While reset is held, a testbench or loader fills the memory through a dedicated preload port.

Top module: `accum_cpu`

## Requirements
- R1: The phase output `phase_o` steps 0 (fetch), 1 (decode), 2 (prepare), 3 (execute) and then wraps to 0. Each phase lasts exactly one clock, so every instruction takes four clocks.
- R2: During fetch, the address select is 0, so memory is addressed by the PC. The IR-load strobe is high, and at the end of fetch the IR takes the word at the PC. The IR does not change in any other phase.
- R3: During decode, the address select is 1, so memory is addressed by IR bits 11:0. The PC-increment strobe is high, and at the end of decode the PC grows by one.
- R4: Opcode 1 (add) sets the ALU select to add during prepare, with `alu_add_o` high. At the end of execute the accumulator becomes the accumulator plus the word at the operand address, modulo 2^16.
- R5: Opcode 2 (jump) raises the PC-load strobe in prepare, and the PC takes IR bits 11:0. The execute phase changes nothing.
- R6: Opcode 3 (shift) acts only in execute. The accumulator is shifted right by one bit, and a zero enters at bit 15. The accumulator changes in no phase other than execute.
- R7: Opcode 4 (store) writes the accumulator to the operand address during execute, with `mem_we_o` high and `mem_addr_o` equal to the address field. No other opcode or phase writes memory.
- R8: In execute, opcode 5 (load) sets the accumulator to the word at the operand address, and opcode 6 (clear) sets it to zero.
- R9: In prepare, opcode 7 jumps when the accumulator is zero, opcode 8 when it is signed greater than zero, and opcode 9 when it is signed less than zero. A jump that is not taken leaves the PC at the incremented value.
- R10: Opcodes 0 and 10 to 15 change neither the accumulator nor memory. Apart from the increment in decode, they leave the PC alone.
- R11: A synchronous active-high reset clears the PC, the accumulator and the IR, and returns the phase to fetch. This also applies in the middle of an instruction.
- R12: When `load_en_i` is high, the memory word at `load_addr_i` takes `load_data_i` on the clock edge. The memory is indexed by the low MEM_AW bits (8 by default) of any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en_i | input | 1 | Preload write enable |
| load_addr_i | input | MEM_AW | Preload word address |
| load_data_i | input | DATA_W | Preload write data |
| phase_o | output | 2 | Current phase (0 fetch, 1 decode, 2 prepare, 3 execute) |
| pc_o | output | DATA_W-4 | Program counter |
| ir_o | output | DATA_W | Instruction register |
| acc_o | output | DATA_W | Accumulator |
| addr_sel_o | output | 1 | Address mux select (0 = PC, 1 = IR address field) |
| ir_ld_o | output | 1 | IR load strobe |
| pc_inc_o | output | 1 | PC increment strobe |
| pc_ld_o | output | 1 | PC load strobe |
| acc_ld_o | output | 1 | Accumulator load strobe |
| acc_shr_o | output | 1 | Accumulator shift-right strobe |
| alu_add_o | output | 1 | ALU operation set to add |
| mem_we_o | output | 1 | Processor memory write strobe |
| mem_addr_o | output | DATA_W-4 | Shared memory address after the mux |
| mem_wdata_o | output | DATA_W | Processor write data (the accumulator) |

## Verification
The assertions check, on every cycle, the behaviour that is fixed by phase. They cover the phase wrap order, the fetch strobes, the IR holding still outside fetch, the PC increment in decode and the PC load only in prepare. They also cover jump targets, the accumulator changing only in execute, the exact shift result, and memory writes only from a store in execute. The bench scenarios are needed for results that depend on data. These include add sums across a grid of operands, load/store round trips through memory, and taken versus not-taken decisions for the three signed conditions at boundary values. They also include the absence of side effects from the unused opcodes and address aliasing into the memory.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_PREP   = 2'd2,
        PH_EXEC   = 2'd3
    } phase_e;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 4'h0,
        OP_ADD   = 4'h1,
        OP_JMP   = 4'h2,
        OP_SHR   = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_CLR   = 4'h6,
        OP_JZ    = 4'h7,
        OP_JGT   = 4'h8,
        OP_JLT   = 4'h9
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_ZERO = 2'd2,
        ALU_HOLD = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic    addr_sel;
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_ld;
        logic    alu_ld;
        alu_op_e alu_op;
        logic    acc_ld;
        logic    acc_shr;
        logic    mem_we;
    } ctrl_t;

endpackage

// File: rtl/acc_phase_gen.sv
module acc_phase_gen
    import acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    typedef struct packed {
        phase_e ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_FETCH:  st_d.ph = PH_DECODE;
            PH_DECODE: st_d.ph = PH_PREP;
            PH_PREP:   st_d.ph = PH_EXEC;
            default:   st_d.ph = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: PH_FETCH};
        else     st_q <= st_d;
    end

    assign phase = st_q.ph;

endmodule

// File: rtl/acc_decoder.sv
module acc_decoder
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  phase_e             phase,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [DATA_W-1:0]  acc,
    output ctrl_t              ctrl
);

    logic acc_zero, acc_neg, acc_pos;

    always_comb begin
        acc_zero = (acc == '0);
        acc_neg  = acc[DATA_W-1];
        acc_pos  = !acc_zero && !acc_neg;
    end

    always_comb begin
        ctrl = '0;
        unique case (phase)
            PH_FETCH: begin
                ctrl.addr_sel = 1'b0;
                ctrl.ir_ld    = 1'b1;
            end
            PH_DECODE: begin
                ctrl.addr_sel = 1'b1;
                ctrl.pc_inc   = 1'b1;
            end
            PH_PREP: begin
                ctrl.addr_sel = 1'b1;
                case (opcode)
                    OP_ADD:  begin ctrl.alu_ld = 1'b1; ctrl.alu_op = ALU_ADD;  end
                    OP_LOAD: begin ctrl.alu_ld = 1'b1; ctrl.alu_op = ALU_PASS; end
                    OP_CLR:  begin ctrl.alu_ld = 1'b1; ctrl.alu_op = ALU_ZERO; end
                    OP_JMP:  ctrl.pc_ld = 1'b1;
                    OP_JZ:   ctrl.pc_ld = acc_zero;
                    OP_JGT:  ctrl.pc_ld = acc_pos;
                    OP_JLT:  ctrl.pc_ld = acc_neg;
                    default: ;
                endcase
            end
            default: begin
                ctrl.addr_sel = 1'b1;
                case (opcode)
                    OP_ADD, OP_LOAD, OP_CLR: ctrl.acc_ld  = 1'b1;
                    OP_SHR:                  ctrl.acc_shr = 1'b1;
                    OP_STORE:                ctrl.mem_we  = 1'b1;
                    default: ;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  ctrl_t                     ctrl,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [DATA_W-OPC_W-1:0]   pc,
    output logic [DATA_W-1:0]         ir,
    output logic [DATA_W-1:0]         acc,
    output logic [DATA_W-OPC_W-1:0]   mem_addr
);

    localparam int ADDR_W = DATA_W - OPC_W;
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        alu_op_e           alu;
    } dp_state_t;

    dp_state_t st_d, st_q;
    logic [DATA_W-1:0] alu_res;

    always_comb begin
        unique case (st_q.alu)
            ALU_ADD:  alu_res = st_q.acc + mem_rdata;
            ALU_PASS: alu_res = mem_rdata;
            ALU_ZERO: alu_res = '0;
            default:  alu_res = st_q.acc;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ctrl.ir_ld) st_d.ir = mem_rdata;
        if (ctrl.pc_ld)       st_d.pc = st_q.ir[ADDR_W-1:0];
        else if (ctrl.pc_inc) st_d.pc = st_q.pc + PC_STEP;
        if (ctrl.alu_ld) st_d.alu = ctrl.alu_op;
        if (ctrl.acc_shr)     st_d.acc = st_q.acc >> 1;
        else if (ctrl.acc_ld) st_d.acc = alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign ir       = st_q.ir;
    assign acc      = st_q.acc;
    assign mem_addr = ctrl.addr_sel ? st_q.ir[ADDR_W-1:0] : st_q.pc;

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en_i,
    input  logic [MEM_AW-1:0]       load_addr_i,
    input  logic [DATA_W-1:0]       load_data_i,
    output logic [1:0]              phase_o,
    output logic [DATA_W-OPC_W-1:0] pc_o,
    output logic [DATA_W-1:0]       ir_o,
    output logic [DATA_W-1:0]       acc_o,
    output logic                    addr_sel_o,
    output logic                    ir_ld_o,
    output logic                    pc_inc_o,
    output logic                    pc_ld_o,
    output logic                    acc_ld_o,
    output logic                    acc_shr_o,
    output logic                    alu_add_o,
    output logic                    mem_we_o,
    output logic [DATA_W-OPC_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]       mem_wdata_o
);

    localparam int ADDR_W = DATA_W - OPC_W;

    phase_e            phase;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc, mem_addr;
    logic [DATA_W-1:0] ir, acc, mem_rdata;
    logic              wr_en;
    logic [MEM_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    acc_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    acc_decoder #(.DATA_W(DATA_W)) u_dec (
        .phase  (phase),
        .opcode (ir[DATA_W-1 -: OPC_W]),
        .acc    (acc),
        .ctrl   (ctrl)
    );

    acc_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ir        (ir),
        .acc       (acc),
        .mem_addr  (mem_addr)
    );

    always_comb begin
        wr_en   = load_en_i | ctrl.mem_we;
        wr_addr = load_en_i ? load_addr_i : mem_addr[MEM_AW-1:0];
        wr_data = load_en_i ? load_data_i : acc;
    end

    acc_mem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (mem_addr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    assign phase_o     = phase;
    assign pc_o        = pc;
    assign ir_o        = ir;
    assign acc_o       = acc;
    assign addr_sel_o  = ctrl.addr_sel;
    assign ir_ld_o     = ctrl.ir_ld;
    assign pc_inc_o    = ctrl.pc_inc;
    assign pc_ld_o     = ctrl.pc_ld;
    assign acc_ld_o    = ctrl.acc_ld;
    assign acc_shr_o   = ctrl.acc_shr;
    assign alu_add_o   = ctrl.alu_ld && (ctrl.alu_op == ALU_ADD);
    assign mem_we_o    = ctrl.mem_we;
    assign mem_addr_o  = mem_addr;
    assign mem_wdata_o = acc;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] acc,
    input logic              addr_sel,
    input logic              ir_ld,
    input logic              pc_ld,
    input logic              mem_we
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [3:0] opc;
    assign opc = ir[DATA_W-1 -: 4];

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == $past(phase) + 2'd1); // R1

    AST_FETCH_STROBES: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd0 |-> (!addr_sel && ir_ld)); // R2

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd0 |=> $stable(ir)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd1 |=> pc == $past(pc) + ONE); // R3

    AST_PC_LOAD_PREP: assert property (@(posedge clk) disable iff (rst)
        pc_ld |-> phase == 2'd2); // R5

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && opc == 4'h2) |=> pc == $past(ir[ADDR_W-1:0])); // R5

    AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3 |=> $stable(acc)); // R6

    AST_SHIFT_RESULT: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && opc == 4'h3) |=> acc == ($past(acc) >> 1)); // R6

    AST_WRITE_STORE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == 2'd3 && opc == 4'h4)); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && ir == '0 && phase == 2'd0)); // R11

endmodule

bind accum_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(DATA_W - 4)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase_o),
    .pc       (pc_o),
    .ir       (ir_o),
    .acc      (acc_o),
    .addr_sel (addr_sel_o),
    .ir_ld    (ir_ld_o),
    .pc_ld    (pc_ld_o),
    .mem_we   (mem_we_o)
);

// File: tb/sim_accum_cpu.sv
module sim_accum_cpu;

    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int AW    = 12;
    localparam int MAW   = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_en = 1'b0;
    logic [MAW-1:0] load_addr = '0;
    logic [DW-1:0]  load_data = '0;
    logic [1:0]     phase;
    logic [AW-1:0]  pc, mem_addr;
    logic [DW-1:0]  ir, acc, mem_wdata;
    logic addr_sel, ir_ld, pc_inc, pc_ld, acc_ld, acc_shr, alu_add, mem_we;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_P/2) clk = ~clk;

    accum_cpu #(.DATA_W(DW), .MEM_AW(MAW)) u0 (
        .clk(clk), .rst(rst),
        .load_en_i(load_en), .load_addr_i(load_addr), .load_data_i(load_data),
        .phase_o(phase), .pc_o(pc), .ir_o(ir), .acc_o(acc),
        .addr_sel_o(addr_sel), .ir_ld_o(ir_ld), .pc_inc_o(pc_inc), .pc_ld_o(pc_ld),
        .acc_ld_o(acc_ld), .acc_shr_o(acc_shr), .alu_add_o(alu_add),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
        return {op, a};
    endfunction

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic poke(input logic [MAW-1:0] a, input logic [DW-1:0] d);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic release_reset();
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (4*n) @(posedge clk);
        @(negedge clk);
    endtask

    logic [DW-1:0] vals [7] = '{16'h0000, 16'h0001, 16'h0005, 16'h7FFF,
                                16'h8000, 16'hFFFF, 16'hFFFB};

    initial begin
        #(CLK_P*150000);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        // R11: reset state after preload
        hold_reset();
        check(pc == 0 && acc == 0 && ir == 0 && phase == 0, "R11 reset",
              {pc, acc[3:0], phase}, 0);

        // R1 R2 R3 R4: phase trace of one add
        poke(8'h00, ins(4'h1, 12'h080));
        poke(8'h80, 16'h1357);
        release_reset();
        check(phase == 0, "R1 fetch phase", phase, 0);
        check(!addr_sel && ir_ld, "R2 fetch strobes", {addr_sel, ir_ld}, 2'b01);
        check(mem_addr == 0, "R2 fetch address is pc", mem_addr, 0);
        @(posedge clk); @(negedge clk);
        check(phase == 1, "R1 decode phase", phase, 1);
        check(ir == ins(4'h1, 12'h080), "R2 ir loaded", ir, ins(4'h1, 12'h080));
        check(addr_sel && pc_inc && mem_addr == 12'h080, "R3 decode strobes",
              {addr_sel, pc_inc, mem_addr}, {2'b11, 12'h080});
        check(pc == 0, "R3 pc before increment", pc, 0);
        @(posedge clk); @(negedge clk);
        check(phase == 2, "R1 prepare phase", phase, 2);
        check(pc == 1, "R3 pc incremented", pc, 1);
        check(alu_add, "R4 alu add select in prepare", alu_add, 1);
        check(acc == 0, "R6 acc unchanged before execute", acc, 0);
        @(posedge clk); @(negedge clk);
        check(phase == 3 && acc_ld, "R4 execute loads acc", {phase, acc_ld}, 3'b111);
        @(posedge clk); @(negedge clk);
        check(phase == 0, "R1 wrap to fetch", phase, 0);
        check(acc == 16'h1357, "R4 add from zero", acc, 16'h1357);

        // R11: reset in the middle of an instruction
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(pc == 0 && acc == 0 && ir == 0 && phase == 0, "R11 mid-instruction reset",
              {pc, acc}, 0);

        // R4: add sweep
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                hold_reset();
                poke(8'h00, ins(4'h5, 12'h080));
                poke(8'h01, ins(4'h1, 12'h081));
                poke(8'h80, vals[i]);
                poke(8'h81, vals[j]);
                release_reset();
                run(2);
                check(acc == DW'(vals[i] + vals[j]), "R4 add sum", acc,
                      DW'(vals[i] + vals[j]));
                check(pc == 2, "R4 pc after add", pc, 2);
            end
        end

        // R6: shift sweep
        for (int i = 0; i < 7; i++) begin
            hold_reset();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h3, 12'h000));
            poke(8'h80, vals[i]);
            release_reset();
            run(1);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(acc == vals[i] && acc_shr, "R6 shift acts only in execute",
                  acc, vals[i]);
            @(posedge clk); @(negedge clk);
            check(acc == (vals[i] >> 1), "R6 shift right", acc, vals[i] >> 1);
        end

        // R7 R8: store, clear, load round trip
        for (int i = 0; i < 7; i++) begin
            hold_reset();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h4, 12'h090));
            poke(8'h02, ins(4'h6, 12'h000));
            poke(8'h03, ins(4'h5, 12'h090));
            poke(8'h80, vals[i] ^ 16'h5A5A);
            poke(8'h90, 16'h0BAD);
            release_reset();
            run(1);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(mem_we && mem_addr == 12'h090 && mem_wdata == (vals[i] ^ 16'h5A5A),
                  "R7 store strobe", {mem_we, mem_addr}, {1'b1, 12'h090});
            @(posedge clk); @(negedge clk);
            check(!mem_we, "R7 no write in fetch", mem_we, 0);
            run(1);
            check(acc == 0, "R8 clear", acc, 0);
            run(1);
            check(acc == (vals[i] ^ 16'h5A5A), "R8 load stored word", acc,
                  vals[i] ^ 16'h5A5A);
        end

        // R5: unconditional jump
        hold_reset();
        poke(8'h00, ins(4'h2, 12'h020));
        poke(8'h20, ins(4'h5, 12'h080));
        poke(8'h80, 16'hC0DE);
        release_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pc_ld && pc == 1, "R5 jump strobe in prepare", {pc_ld, pc}, {1'b1, 12'h001});
        @(posedge clk); @(negedge clk);
        check(pc == 12'h020 && acc == 0, "R5 pc at target, execute idle", pc, 12'h020);
        @(posedge clk); @(negedge clk);
        check(pc == 12'h020, "R5 execute keeps pc", pc, 12'h020);
        run(1);
        check(acc == 16'hC0DE, "R5 target instruction runs", acc, 16'hC0DE);

        // R9: conditional jump sweep
        for (int op = 7; op <= 9; op++) begin
            for (int i = 0; i < 7; i++) begin
                bit taken;
                case (op)
                    7:       taken = (vals[i] == 0);
                    8:       taken = ($signed(vals[i]) > 0);
                    default: taken = ($signed(vals[i]) < 0);
                endcase
                hold_reset();
                poke(8'h00, ins(4'h5, 12'h080));
                poke(8'h01, ins(4'(op), 12'h030));
                poke(8'h80, vals[i]);
                release_reset();
                run(2);
                check(pc == (taken ? 12'h030 : 12'h002), $sformatf("R9 cond op %0d", op),
                      pc, taken ? 12'h030 : 12'h002);
            end
        end

        // R10: unused opcodes have no effect
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 9) continue;
            hold_reset();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'(op), 12'h081));
            poke(8'h02, ins(4'h5, 12'h081));
            poke(8'h80, 16'h1234);
            poke(8'h81, 16'h0F0F);
            release_reset();
            run(2);
            check(acc == 16'h1234 && pc == 2, $sformatf("R10 opcode %0d acc/pc", op),
                  {acc, 4'h0, pc}, {16'h1234, 4'h0, 12'h002});
            run(1);
            check(acc == 16'h0F0F, $sformatf("R10 opcode %0d memory", op), acc, 16'h0F0F);
        end

        // R12: preload and address aliasing onto low bits
        hold_reset();
        poke(8'h00, ins(4'h5, 12'hFFF));
        poke(8'hFF, 16'hA5C3);
        release_reset();
        run(1);
        check(acc == 16'hA5C3, "R12 preload with aliased address", acc, 16'hA5C3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule